// File: doc/BRIEF.md
# Descriptor Chain Transfer Sequencer

This block runs a list of linked transfer descriptors that sit in system memory. Each descriptor occupies four consecutive 32-bit words. For each one, the sequencer reads the descriptor over a simple request/acknowledge memory port and checks that hardware owns it. It then hands one half-duplex transfer command to a downstream serial shifter and waits for the shifter's done strobe. When the shifter finishes, the sequencer writes the control word back with ownership cleared and follows the link to the next descriptor. The shifter moves the payload bytes. This block only sequences the commands.

Software sets up a base pointer and then writes a three-bit control value to start the walk. One bit enables the engine, one bit allows polling of descriptors that are not yet owned, and one bit starts the walk. Writing zero to the control value stops everything. Each descriptor decides a set of things for its own transfer:

- the lane width, the direction and the bit order;
- the chip select;
- whether the chip select is dropped after it;
- whether it raises a descriptor-done event or a packet-complete event.

A one-cycle error event reports three conditions: a descriptor that is not owned when polling is off, an oversize length, and a broken chain.

Top module: `bd_chain_engine`

## Requirements
- R1: A walk begins only on a control write with bit 0 (engine enable) and bit 2 (start) both set while idle. Bit 1 of that write selects polling. Any other nonzero control write while idle issues no memory request and changes no memory word.
- R2: A descriptor at address P is read as control at P, status at P+4, buffer address at P+8 and next pointer at P+12. The first descriptor is read at the base register. The command carries the buffer word as cmd_addr and control bits 8:0 as cmd_len.
- R3: The command fields are decoded from control as follows:
  - cmd_rx is bit 20 (1 means receive);
  - cmd_lanes is 2 when bit 23 is set, otherwise 1 when bit 22 is set, otherwise 0;
  - cmd_ddr is bit 21;
  - cmd_lsb_first is bit 25;
  - cmd_stat_poll is bit 27;
  - cmd_cs is bits 29:28.
- R4: A length above MAX_LEN (default 256) produces an error event and no command. A length equal to MAX_LEN is transferred.
- R5: After cmd_done, the control word is written back to address P with bit 31 (hardware ownership) cleared. Then ev_bd_done pulses if bit 16 was set.
- R6: After a descriptor without bit 19 (end of list), the next pointer is fetched and processed. After a descriptor with bit 19, the engine goes idle.
- R7: A zero next pointer on a descriptor without bit 19 raises ev_err after that descriptor's transfer, and the engine stops.
- R8: If a fetched descriptor lacks bit 31, the engine raises ev_err when polling is off. When polling is on, it re-reads the descriptor until bit 31 is set.
- R9: cs_assert rises with a command and stays high across descriptors. It is released only after a descriptor with bit 30 set. When bit 17 is set, ev_pkt_done pulses one cycle after the write-back, in the first cycle where that release is visible.
- R10: A control write of zero returns the engine to idle in the next cycle, with the chip select released and no further memory requests.
- R11: ev_bd_done, ev_pkt_done and ev_err are single-cycle pulses, never two at once. After an error the chip select is released.
- R12: After reset the engine is idle, with no memory request, no command, chip select released and no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control value: bit0 enable, bit1 polling, bit2 start |
| base_wr | input | 1 | Base pointer write strobe |
| base_wdata | input | AW | Byte address of the first descriptor |
| busy | output | 1 | Engine is walking the chain |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data (control write-back) |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Transfer command held until cmd_done |
| cmd_rx | output | 1 | Receive direction |
| cmd_lanes | output | 2 | 0 single, 1 dual, 2 quad |
| cmd_ddr | output | 1 | Double data rate |
| cmd_lsb_first | output | 1 | Least significant bit first |
| cmd_stat_poll | output | 1 | Status poll transfer |
| cmd_cs | output | 2 | Chip select for this transfer |
| cmd_len | output | 9 | Byte count |
| cmd_addr | output | AW | Payload buffer address |
| cmd_done | input | 1 | Shifter finished the command |
| cs_assert | output | 1 | Chip select held active |
| cs_sel | output | 2 | Chip select number being held |
| ev_bd_done | output | 1 | Descriptor completed pulse |
| ev_pkt_done | output | 1 | Packet completed pulse |
| ev_err | output | 1 | Error pulse |

## Verification
The bench builds the engine with AW = 16 and MAX_LEN = 256. A 64-word memory model therefore holds every descriptor, and the field at the top of the 9-bit length, 256 bytes, sits exactly on the limit while 257 crosses it. The short address width puts the zero-pointer and base-offset cases within a few descriptors. The memory and shifter models answer with one-cycle latency, so polling, halting during a held chip select, and the timing of the packet event against the release can all be observed in tens of cycles.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 9;

  localparam int B_BD_EV   = 16;
  localparam int B_PKT_EV  = 17;
  localparam int B_EOL     = 19;
  localparam int B_RX      = 20;
  localparam int B_DDR     = 21;
  localparam int B_DUAL    = 22;
  localparam int B_QUAD    = 23;
  localparam int B_LSB     = 25;
  localparam int B_SPOLL   = 27;
  localparam int B_CS_LO   = 28;
  localparam int B_CS_REL  = 30;
  localparam int B_OWN     = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_CMD, ST_WB, ST_POST, ST_PKT, ST_ERR
  } bdc_state_e;

  function automatic logic [1:0] lanes_of(input logic [WORD_W-1:0] c);
    if (c[B_QUAD]) return 2'd2;
    if (c[B_DUAL]) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input logic [WORD_W-1:0] c);
    return c[LEN_W-1:0];
  endfunction

  function automatic logic [1:0] cs_of(input logic [WORD_W-1:0] c);
    return c[B_CS_LO+1:B_CS_LO];
  endfunction

  function automatic logic [WORD_W-1:0] disown(input logic [WORD_W-1:0] c);
    logic [WORD_W-1:0] r;
    r = c;
    r[B_OWN] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/bdc_regs.sv
module bdc_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_wdata,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  input  logic          idle,
  output logic          start,
  output logic          halt,
  output logic          poll_sel,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_wr) base_q <= base_wdata;
  end

  assign start    = ctl_wr && idle && ctl_wdata[0] && ctl_wdata[2];
  assign halt     = ctl_wr && (ctl_wdata == 3'b000);
  assign poll_sel = ctl_wdata[1];
endmodule

// File: rtl/bdc_desc_store.sv
module bdc_desc_store (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic [1:0]  idx,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl,
  output logic [31:0] bufa,
  output logic [31:0] nxt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      bufa <= '0;
      nxt  <= '0;
    end else if (cap) begin
      case (idx)
        2'd0:    ctrl <= wdata;
        2'd2:    bufa <= wdata;
        2'd3:    nxt  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bdc_csel.sv
module bdc_csel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grab,
  input  logic [1:0] grab_sel,
  input  logic       rel,
  input  logic       drop,
  output logic       cs_on,
  output logic [1:0] cs_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_on  <= 1'b0;
      cs_sel <= 2'd0;
    end else if (drop || rel) begin
      cs_on  <= 1'b0;
    end else if (grab) begin
      cs_on  <= 1'b1;
      cs_sel <= grab_sel;
    end
  end

  AST_CS_RISE_NEEDS_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_on) |-> $past(grab)); // R9
endmodule

// File: rtl/bd_chain_engine.sv
module bd_chain_engine
  import bdc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [2:0]       ctl_wdata,
  input  logic             base_wr,
  input  logic [AW-1:0]    base_wdata,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             cmd_valid,
  output logic             cmd_rx,
  output logic [1:0]       cmd_lanes,
  output logic             cmd_ddr,
  output logic             cmd_lsb_first,
  output logic             cmd_stat_poll,
  output logic [1:0]       cmd_cs,
  output logic [LEN_W-1:0] cmd_len,
  output logic [AW-1:0]    cmd_addr,
  input  logic             cmd_done,
  output logic             cs_assert,
  output logic [1:0]       cs_sel,
  output logic             ev_bd_done,
  output logic             ev_pkt_done,
  output logic             ev_err
);
  localparam int PAD_W = AW - 4;

  bdc_state_e    state;
  logic [1:0]    idx;
  logic [AW-1:0] ptr;
  logic          poll_q;

  logic          start, halt, poll_sel;
  logic [AW-1:0] base_q;
  logic [31:0]   ctrl_w, buf_w, next_w;

  logic fetch_cap, owned, too_long, go_cmd, cs_rel, cs_drop, next_null;

  bdc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .base_wr(base_wr), .base_wdata(base_wdata), .idle(state == ST_IDLE),
    .start(start), .halt(halt), .poll_sel(poll_sel), .base_q(base_q)
  );

  assign fetch_cap = (state == ST_FETCH) && mem_ack;

  bdc_desc_store u_store (
    .clk(clk), .rst_n(rst_n), .cap(fetch_cap), .idx(idx), .wdata(mem_rdata),
    .ctrl(ctrl_w), .bufa(buf_w), .nxt(next_w)
  );

  assign owned     = ctrl_w[B_OWN];
  assign too_long  = 32'(len_of(ctrl_w)) > 32'(MAX_LEN);
  assign go_cmd    = (state == ST_CHECK) && owned && !too_long && !halt;
  assign cs_rel    = (state == ST_POST) && ctrl_w[B_CS_REL];
  assign cs_drop   = halt || (state == ST_ERR);
  assign next_null = (next_w == 32'd0);

  bdc_csel u_csel (
    .clk(clk), .rst_n(rst_n), .grab(go_cmd), .grab_sel(cs_of(ctrl_w)),
    .rel(cs_rel), .drop(cs_drop), .cs_on(cs_assert), .cs_sel(cs_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= 2'd0;
      ptr    <= '0;
      poll_q <= 1'b0;
    end else if (halt) begin
      state <= ST_IDLE;
      idx   <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          ptr    <= base_q;
          poll_q <= poll_sel;
          idx    <= 2'd0;
          state  <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack) begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!owned)        state <= poll_q ? ST_FETCH : ST_ERR;
          else if (too_long) state <= ST_ERR;
          else               state <= ST_CMD;
        end
        ST_CMD:  if (cmd_done) state <= ST_WB;
        ST_WB:   if (mem_ack)  state <= ST_POST;
        ST_POST: state <= ST_PKT;
        ST_PKT: begin
          if (ctrl_w[B_EOL])  state <= ST_IDLE;
          else if (next_null) state <= ST_ERR;
          else begin
            ptr   <= next_w[AW-1:0];
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_FETCH) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_addr  = (state == ST_WB) ? ptr : ptr + {{PAD_W{1'b0}}, idx, 2'b00};
  assign mem_wdata = disown(ctrl_w);

  assign cmd_valid     = (state == ST_CMD);
  assign cmd_rx        = ctrl_w[B_RX];
  assign cmd_lanes     = lanes_of(ctrl_w);
  assign cmd_ddr       = ctrl_w[B_DDR];
  assign cmd_lsb_first = ctrl_w[B_LSB];
  assign cmd_stat_poll = ctrl_w[B_SPOLL];
  assign cmd_cs        = cs_of(ctrl_w);
  assign cmd_len       = len_of(ctrl_w);
  assign cmd_addr      = buf_w[AW-1:0];

  assign ev_bd_done  = (state == ST_POST) && ctrl_w[B_BD_EV];
  assign ev_pkt_done = (state == ST_PKT) && ctrl_w[B_PKT_EV];
  assign ev_err      = (state == ST_ERR);

  AST_CMD_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cs_assert); // R9
  AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_bd_done, ev_pkt_done, ev_err})); // R11
  AST_WB_DISOWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[B_OWN]); // R5
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (32'(cmd_len) <= 32'(MAX_LEN))); // R4
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!busy && !cs_assert && !mem_req)); // R10
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done && !halt) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len))); // R3
  AST_ERR_DROPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err && !halt) |=> !cs_assert); // R11
endmodule

// File: tb/tb_bd_chain_engine.sv
module tb_bd_chain_engine;
  localparam int AW = 16;
  localparam int MAX_LEN = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ctl_wr = 1'b0;
  logic [2:0] ctl_wdata = 3'b000;
  logic base_wr = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic busy, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic cmd_valid, cmd_rx, cmd_ddr, cmd_lsb_first, cmd_stat_poll, cmd_done;
  logic [1:0] cmd_lanes, cmd_cs, cs_sel;
  logic [8:0] cmd_len;
  logic [AW-1:0] cmd_addr;
  logic cs_assert, ev_bd_done, ev_pkt_done, ev_err;

  bd_chain_engine #(.AW(AW), .MAX_LEN(MAX_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .base_wr(base_wr), .base_wdata(base_wdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_rx(cmd_rx), .cmd_lanes(cmd_lanes), .cmd_ddr(cmd_ddr),
    .cmd_lsb_first(cmd_lsb_first), .cmd_stat_poll(cmd_stat_poll), .cmd_cs(cmd_cs),
    .cmd_len(cmd_len), .cmd_addr(cmd_addr), .cmd_done(cmd_done),
    .cs_assert(cs_assert), .cs_sel(cs_sel),
    .ev_bd_done(ev_bd_done), .ev_pkt_done(ev_pkt_done), .ev_err(ev_err)
  );

  // memory model: host writes on the rising edge, engine traffic on the falling edge
  logic [31:0] mem [0:63];
  logic hw_en = 1'b0;
  logic [5:0] hw_idx = '0;
  logic [31:0] hw_val = '0;
  logic mem_ack_r = 1'b0;
  logic [31:0] mem_rdata_r = '0;
  assign mem_ack = mem_ack_r;
  assign mem_rdata = mem_rdata_r;

  always @(clk) begin
    if (clk) begin
      if (hw_en) mem[hw_idx] <= hw_val;
    end else begin
      if (mem_req && !mem_ack_r) begin
        mem_ack_r <= 1'b1;
        mem_rdata_r <= mem[mem_addr[7:2]];
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      end else begin
        mem_ack_r <= 1'b0;
      end
    end
  end

  // shifter model and command log
  logic done_r = 1'b0;
  assign cmd_done = done_r;
  int cmd_n = 0;
  logic [16:0] lg_f [0:31];
  logic [AW-1:0] lg_a [0:31];
  logic lg_cs [0:31];
  always @(negedge clk) begin
    if (cmd_valid && !done_r) begin
      done_r <= 1'b1;
      if (cmd_n < 32) begin
        lg_f[cmd_n] <= {cmd_rx, cmd_lanes, cmd_ddr, cmd_lsb_first, cmd_stat_poll, cmd_cs, cmd_len};
        lg_a[cmd_n] <= cmd_addr;
        lg_cs[cmd_n] <= cs_assert && (cs_sel == cmd_cs);
      end
      cmd_n <= cmd_n + 1;
    end else begin
      done_r <= 1'b0;
    end
  end

  // event monitor
  int cyc = 0, n_bd = 0, n_pkt = 0, n_err = 0, n_fall = 0, fall_cyc = -1, pkt_cyc = -2;
  logic prev_cs = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_cs <= cs_assert;
    if (prev_cs && !cs_assert) begin n_fall <= n_fall + 1; fall_cyc <= cyc; end
    if (ev_bd_done) n_bd <= n_bd + 1;
    if (ev_pkt_done) begin n_pkt <= n_pkt + 1; pkt_cyc <= cyc; end
    if (ev_err) n_err <= n_err + 1;
  end

  int errors = 0, checks = 0;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int byte_addr, input logic [31:0] v);
    hw_en = 1'b1; hw_idx = 6'(byte_addr >> 2); hw_val = v;
    @(posedge clk); @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic desc(input int a, input logic [31:0] c, input logic [31:0] b, input logic [31:0] n);
    put(a, c); put(a + 4, 32'h0); put(a + 8, b); put(a + 12, n);
  endtask

  task automatic ctl(input logic [2:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 3'b000;
  endtask

  task automatic setbase(input int a);
    base_wr = 1'b1; base_wdata = AW'(a);
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  // vector table: control word and expected {rx, lanes, ddr, lsb, spoll, cs, len}
  localparam logic [31:0] VCTRL [4] = '{32'h8008_0010, 32'h9298_0100, 32'hA868_0001, 32'hF0D8_00FF};
  localparam logic [16:0] VEXP [4] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 9'd16},
    {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd1, 9'd256},
    {1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 2'd2, 9'd1},
    {1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd3, 9'd255}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  initial begin
    int n0, e0, b0, p0, f0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !mem_req && !cmd_valid && !cs_assert && !ev_bd_done && !ev_pkt_done && !ev_err,
        "R12 reset idle", {busy, mem_req, cmd_valid, cs_assert}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2, R3, R5, R6
    for (int i = 0; i < 4; i++) begin
      desc(0, VCTRL[i], 32'h1000 + 32'(i * 16), 32'h0);
      setbase(0);
      n0 = cmd_n;
      ctl(3'b111);
      wait_idle();
      chk(cmd_n == n0 + 1, "R6 stop at end of list", cmd_n - n0, 1);
      chk(lg_f[n0] == VEXP[i], "R3 command fields", lg_f[n0], VEXP[i]);
      chk(lg_a[n0] == AW'(32'h1000 + 32'(i * 16)), "R2 buffer address", lg_a[n0], 32'h1000 + i * 16);
      chk(mem[0] == (VCTRL[i] & 32'h7FFF_FFFF), "R5 write-back clears ownership", mem[0], VCTRL[i] & 32'h7FFF_FFFF);
    end

    // R1 incomplete start values are ignored
    desc(0, 32'h8008_0004, 32'h2000, 32'h0);
    n0 = cmd_n;
    ctl(3'b011);
    repeat (10) @(negedge clk);
    ctl(3'b100);
    repeat (10) @(negedge clk);
    chk(!busy && cmd_n == n0, "R1 no start without enable and start", cmd_n - n0, 0);
    chk(mem[0] == 32'h8008_0004, "R1 memory untouched", mem[0], 32'h8008_0004);

    // R6 R9 R5 three-descriptor packet with one release at the end
    desc(8'h00, 32'h9001_0008, 32'h3000, 32'h40);
    desc(8'h40, 32'h9000_0004, 32'h3100, 32'h80);
    desc(8'h80, 32'hD00A_0002, 32'h3200, 32'h0);
    setbase(0);
    n0 = cmd_n; b0 = n_bd; p0 = n_pkt; f0 = n_fall;
    ctl(3'b111);
    wait_idle();
    chk(cmd_n == n0 + 3, "R6 chain followed", cmd_n - n0, 3);
    chk(lg_a[n0] == 16'h3000 && lg_a[n0+1] == 16'h3100 && lg_a[n0+2] == 16'h3200,
        "R6 chain order", lg_a[n0+1], 16'h3100);
    chk(lg_cs[n0] && lg_cs[n0+1] && lg_cs[n0+2], "R9 cs held on every command", lg_cs[n0+1], 1);
    chk(n_fall == f0 + 1, "R9 single release", n_fall - f0, 1);
    chk(n_pkt == p0 + 1 && pkt_cyc == fall_cyc, "R9 packet event in release cycle", pkt_cyc, fall_cyc);
    chk(n_bd == b0 + 1, "R5 descriptor event only when requested", n_bd - b0, 1);
    chk(mem[16] == 32'h1000_0004 && mem[32] == 32'h500A_0002, "R5 write-backs", mem[32], 32'h500A_0002);

    // R7 zero next pointer without end of list; R2 base offset
    desc(8'hC0, 32'h8000_0003, 32'h4000, 32'h0);
    setbase(8'hC0);
    n0 = cmd_n; e0 = n_err;
    ctl(3'b111);
    wait_idle();
    chk(cmd_n == n0 + 1 && lg_a[n0] == 16'h4000, "R2 fetch from base register", lg_a[n0], 16'h4000);
    chk(n_err == e0 + 1 && !busy, "R7 null link error", n_err - e0, 1);
    chk(!cs_assert, "R11 error releases chip select", cs_assert, 0);

    // R4 length limit
    desc(8'hC0, 32'h8008_0101, 32'h4100, 32'h0);
    n0 = cmd_n; e0 = n_err;
    ctl(3'b111);
    wait_idle();
    chk(cmd_n == n0 && n_err == e0 + 1, "R4 oversize length rejected", n_err - e0, 1);

    // R8 not owned, polling off
    desc(8'hC0, 32'h0008_0010, 32'h4200, 32'h0);
    n0 = cmd_n; e0 = n_err;
    ctl(3'b101);
    wait_idle();
    chk(cmd_n == n0 && n_err == e0 + 1, "R8 unowned with polling off", n_err - e0, 1);
    chk(n_err == e0 + 1, "R11 error pulse lasts one cycle", n_err - e0, 1);

    // R8 polling until owned
    n0 = cmd_n; e0 = n_err;
    ctl(3'b111);
    repeat (40) @(negedge clk);
    chk(busy && cmd_n == n0, "R8 polling waits", cmd_n - n0, 0);
    put(8'hC0, 32'h8008_0010);
    wait_idle();
    chk(cmd_n == n0 + 1 && n_err == e0 && lg_a[n0] == 16'h4200, "R8 proceeds once owned", cmd_n - n0, 1);

    // R9 R10 halt while holding chip select across descriptors
    desc(8'h00, 32'hA000_0004, 32'h5000, 32'h40);
    desc(8'h40, 32'h2008_0004, 32'h5100, 32'h0);
    setbase(0);
    n0 = cmd_n;
    ctl(3'b111);
    for (int k = 0; k < 200 && cmd_n == n0; k++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(busy && cs_assert && cs_sel == 2'd2, "R9 cs held between descriptors", {busy, cs_assert, cs_sel}, 4'b1110);
    ctl(3'b000);
    chk(!busy && !cs_assert, "R10 halt to idle", {busy, cs_assert}, 0);
    repeat (10) @(negedge clk);
    chk(!mem_req && cmd_n == n0 + 1, "R10 no traffic after halt", mem_req, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule